// File: doc/BRIEF.md
# Receive Descriptor Chain DMA Engine

This block moves received frames from a byte stream into host memory under the control of a chain of descriptors. Each descriptor occupies four consecutive 32-bit words: a link to the following descriptor, a status word, the start address of a data buffer, and a length/control word. Software writes the address of the first descriptor into the list pointer register. The engine then reads that descriptor over a simple memory master port, stores the bytes of the next frame into the named buffer, and writes back a status word once the frame is complete. It then follows the link word to the next descriptor.

A descriptor whose status word already carries the filled flag has not yet been handed back by software. In that case the engine takes no bytes. It waits a programmable number of poll units and then reads the same descriptor again. A frame that is longer than its buffer is cut at the buffer capacity, and the cut is flagged in the status word. Error flags from the upstream receiver arrive with the last byte of each frame and are copied into the status word. A single-cycle done pulse reports each status writeback. A link of zero, or a list pointer of zero, leaves the engine idle.

Top module: `rxd_dma_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mem_req_o`, `done_o` and `rx_ready_o` are low.
- R2: While the current descriptor address is zero, the engine makes no memory request and holds `rx_ready_o` low. This holds after reset, and after a write of zero to the list pointer while idle or poll-waiting.
- R3: A descriptor fetch reads the words at offsets 0, 4, 8 and 12 from the descriptor address, in that order. Offset 0 is the link, 4 is the status, 8 is the buffer address and 12 is the length/control word. The first fetch uses the address last written to the list pointer.
- R4: A fetched descriptor with status bit 15 set causes no byte transfer and no write. The memory port then stays idle for exactly poll_period × UNIT_CYCLES + 1 cycles, after which the same descriptor is fetched again.
- R5: Frame byte i is stored at buffer address + i, little-endian within each 32-bit word. Only the lanes holding frame bytes are enabled in `mem_be_o`, so the other bytes of a partial last word keep their previous contents. Buffers must be word aligned.
- R6: The capacity is bits 12:0 of the length/control word. Bytes beyond the capacity are accepted but not written, the stored count equals the capacity, and status bit 14 is set. A frame of exactly the capacity leaves bit 14 clear.
- R7: The status word is written to descriptor address + 4. Bits 12:0 hold the stored byte count and bit 15 is set. Bits 20:16 hold `rx_err_i` as sampled with the last byte, bit 14 holds the overflow flag, and all other bits are zero.
- R8: `done_o` is a single-cycle pulse, raised in the cycle after the status write is acknowledged, once for each completed descriptor.
- R9: A memory request keeps its address, write data and direction stable until `mem_ack_i`.
- R10: After a status writeback the engine fetches the descriptor named by the link word. A link of zero makes it idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| list_ptr_we_i | input | 1 | List pointer write strobe |
| list_ptr_i | input | AW | Address of the first descriptor |
| poll_we_i | input | 1 | Poll period write strobe |
| poll_period_i | input | PERIOD_W | Poll period in poll units |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Byte address, word aligned |
| mem_be_o | output | 4 | Byte lane enables for writes |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Transfer accepted; read data valid in this cycle |
| mem_rdata_i | input | 32 | Read data |
| rx_valid_i | input | 1 | Frame byte valid |
| rx_ready_o | output | 1 | Engine takes a byte in this cycle |
| rx_data_i | input | 8 | Frame byte |
| rx_last_i | input | 1 | Marks the last byte of a frame |
| rx_err_i | input | 5 | Receiver error flags, valid with the last byte |
| done_o | output | 1 | Descriptor completion pulse |

## Verification
The bench builds the engine with a 16-bit address and UNIT_CYCLES = 2. With these values a poll window of a few units is short enough to count to the exact cycle, and a longer one leaves a safe gap for redirecting the list pointer in mid-wait. Descriptor capacities of 5, 8 and 64 bytes let a handful of bytes reach truncation, an exact fill, and partial last words at several lanes. A memory model with adjustable acknowledge latency holds requests for several cycles, so request stability is exercised.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int LEN_W        = 13;
  localparam int STAT_OWN_BIT = 15;
  localparam int STAT_OVF_BIT = 14;
  localparam int STAT_ERR_LSB = 16;
  localparam int ERR_W        = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_WAIT, ST_RECV, ST_WDATA, ST_WSTAT
  } rxd_state_e;

  function automatic logic [31:0] pack_status(input logic [LEN_W-1:0] cnt,
                                              input logic [ERR_W-1:0] err,
                                              input logic ovf);
    logic [31:0] s;
    s = '0;
    s[LEN_W-1:0] = cnt;
    s[STAT_OWN_BIT] = 1'b1;
    s[STAT_OVF_BIT] = ovf;
    s[STAT_ERR_LSB +: ERR_W] = err;
    return s;
  endfunction
endpackage

// File: rtl/rxd_poll_timer.sv
module rxd_poll_timer #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] value_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= value_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/rxd_lane_pack.sv
module rxd_lane_pack #(
  parameter int LANES = 4,
  localparam int LW   = $clog2(LANES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               put_i,
  input  logic [LW-1:0]      lane_i,
  input  logic [7:0]         byte_i,
  output logic [8*LANES-1:0] word_o,
  output logic [LANES-1:0]   be_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] data_q;
    logic       vld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q <= '0;
        vld_q  <= 1'b0;
      end else if (clr_i) begin
        vld_q  <= 1'b0;
      end else if (put_i && lane_i == LW'(g)) begin
        data_q <= byte_i;
        vld_q  <= 1'b1;
      end
    end
    assign word_o[8*g +: 8] = data_q;
    assign be_o[g]          = vld_q;
  end
endmodule

// File: rtl/rxd_dma_engine.sv
module rxd_dma_engine
  import rxd_pkg::*;
#(
  parameter int AW           = 32,
  parameter int PERIOD_W     = 8,
  parameter int UNIT_CYCLES  = 8,
  parameter int POLL_DEFAULT = 100,
  localparam int TW          = PERIOD_W + $clog2(UNIT_CYCLES) + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                list_ptr_we_i,
  input  logic [AW-1:0]       list_ptr_i,
  input  logic                poll_we_i,
  input  logic [PERIOD_W-1:0] poll_period_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [AW-1:0]       mem_addr_o,
  output logic [3:0]          mem_be_o,
  output logic [31:0]         mem_wdata_o,
  input  logic                mem_ack_i,
  input  logic [31:0]         mem_rdata_i,
  input  logic                rx_valid_i,
  output logic                rx_ready_o,
  input  logic [7:0]          rx_data_i,
  input  logic                rx_last_i,
  input  logic [ERR_W-1:0]    rx_err_i,
  output logic                done_o
);
  rxd_state_e          state_q;
  logic [AW-1:0]       cur_q, next_q, buf_q, wptr_q;
  logic [1:0]          idx_q;
  logic                own_q, ovf_q, last_q, done_q;
  logic [LEN_W-1:0]    cap_q, cnt_q;
  logic [ERR_W-1:0]    err_q;
  logic [PERIOD_W-1:0] poll_q;

  logic        fetch_end, byte_fits, word_full, put, clr, poll_expired;
  logic [31:0] lane_word;
  logic [3:0]  lane_be;

  assign fetch_end = (state_q == ST_FETCH) && mem_ack_i && (idx_q == 2'd3);
  assign byte_fits = cnt_q < cap_q;
  assign word_full = byte_fits && (cnt_q[1:0] == 2'd3);
  assign put       = (state_q == ST_RECV) && rx_valid_i && byte_fits;
  assign clr       = fetch_end || ((state_q == ST_WDATA) && mem_ack_i);

  rxd_lane_pack #(.LANES(4)) u_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .put_i  (put),
    .lane_i (cnt_q[1:0]),
    .byte_i (rx_data_i),
    .word_o (lane_word),
    .be_o   (lane_be)
  );

  rxd_poll_timer #(.CW(TW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (fetch_end && own_q),
    .value_i   (TW'(poll_q) * TW'(UNIT_CYCLES)),
    .expired_o (poll_expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      next_q  <= '0;
      buf_q   <= '0;
      wptr_q  <= '0;
      idx_q   <= '0;
      own_q   <= 1'b0;
      ovf_q   <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
      cap_q   <= '0;
      cnt_q   <= '0;
      err_q   <= '0;
      poll_q  <= PERIOD_W'(POLL_DEFAULT);
    end else begin
      done_q <= 1'b0;
      if (poll_we_i) poll_q <= poll_period_i;
      unique case (state_q)
        ST_IDLE: begin
          if (list_ptr_we_i) cur_q <= list_ptr_i;
          else if (cur_q != '0) begin
            state_q <= ST_FETCH;
            idx_q   <= '0;
          end
        end
        ST_FETCH: if (mem_ack_i) begin
          idx_q <= idx_q + 2'd1;
          unique case (idx_q)
            2'd0: next_q <= mem_rdata_i[AW-1:0];
            2'd1: own_q  <= mem_rdata_i[STAT_OWN_BIT];
            2'd2: buf_q  <= mem_rdata_i[AW-1:0];
            default: begin
              cap_q   <= mem_rdata_i[LEN_W-1:0];
              cnt_q   <= '0;
              ovf_q   <= 1'b0;
              err_q   <= '0;
              last_q  <= 1'b0;
              wptr_q  <= buf_q;
              state_q <= own_q ? ST_WAIT : ST_RECV;
            end
          endcase
        end
        ST_WAIT: begin
          if (list_ptr_we_i) begin
            cur_q   <= list_ptr_i;
            state_q <= ST_IDLE;
          end else if (poll_expired) begin
            state_q <= ST_FETCH;
            idx_q   <= '0;
          end
        end
        ST_RECV: if (rx_valid_i) begin
          if (byte_fits) cnt_q <= cnt_q + 1'b1;
          else           ovf_q <= 1'b1;
          if (rx_last_i) begin
            err_q  <= rx_err_i;
            last_q <= 1'b1;
          end
          // flush on a full word, or at frame end when any lane holds data
          if (word_full || (rx_last_i && (byte_fits || lane_be != '0)))
            state_q <= ST_WDATA;
          else if (rx_last_i)
            state_q <= ST_WSTAT;
        end
        ST_WDATA: if (mem_ack_i) begin
          wptr_q  <= wptr_q + AW'(4);
          state_q <= last_q ? ST_WSTAT : ST_RECV;
        end
        ST_WSTAT: if (mem_ack_i) begin
          done_q  <= 1'b1;
          cur_q   <= next_q;
          idx_q   <= '0;
          state_q <= (next_q == '0) ? ST_IDLE : ST_FETCH;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_be_o    = 4'hf;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + AW'({idx_q, 2'b00});
      end
      ST_WDATA: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = wptr_q;
        mem_be_o    = lane_be;
        mem_wdata_o = lane_word;
      end
      ST_WSTAT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_q + AW'(4);
        mem_wdata_o = pack_status(cnt_q, err_q, ovf_q);
      end
      default: ;
    endcase
  end

  assign rx_ready_o = (state_q == ST_RECV);
  assign done_o     = done_q;
endmodule

// File: rtl/rxd_dma_checker.sv
module rxd_dma_checker #(
  parameter int AW    = 32,
  parameter int LEN_W = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic             mem_ack_i,
  input logic [AW-1:0]    mem_addr_o,
  input logic [31:0]      mem_wdata_o,
  input logic             rx_ready_o,
  input logic             done_o,
  input logic [AW-1:0]    cur_q,
  input logic [LEN_W-1:0] cnt_q,
  input logic [LEN_W-1:0] cap_q
);
  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_wdata_o) && $stable(mem_we_o));

  a_r8_done_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_req_o && mem_we_o && mem_ack_i));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_cnt_within_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= cap_q);

  a_r2_null_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == '0) |-> !mem_req_o && !rx_ready_o);

  a_r5_no_rx_during_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_ready_o && mem_req_o));
endmodule

bind rxd_dma_engine rxd_dma_checker #(.AW(AW), .LEN_W(rxd_pkg::LEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_ack_i   (mem_ack_i),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .rx_ready_o  (rx_ready_o),
  .done_o      (done_o),
  .cur_q       (cur_q),
  .cnt_q       (cnt_q),
  .cap_q       (cap_q)
);

// File: tb/rxd_dma_engine_tb.sv
`timescale 1ns/1ps
module rxd_dma_engine_tb;
  localparam int AW   = 16;
  localparam int UNIT = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          lp_we = 1'b0;
  logic [AW-1:0] lp_val = '0;
  logic          pp_we = 1'b0;
  logic [7:0]    pp_val = '0;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_be;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          rx_valid = 1'b0, rx_ready, rx_last = 1'b0, done;
  logic [7:0]    rx_data = '0;
  logic [4:0]    rx_err = '0;

  rxd_dma_engine #(.AW(AW), .UNIT_CYCLES(UNIT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .list_ptr_we_i(lp_we), .list_ptr_i(lp_val),
    .poll_we_i(pp_we), .poll_period_i(pp_val),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_data_i(rx_data),
    .rx_last_i(rx_last), .rx_err_i(rx_err), .done_o(done)
  );

  // memory model with adjustable acknowledge latency
  logic [31:0] mem [0:255];
  int lat = 0;
  int wcnt = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      wcnt      <= 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (wcnt >= lat) begin
          wcnt    <= 0;
          mem_ack <= 1'b1;
          if (mem_we) begin
            for (int b = 0; b < 4; b++)
              if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
          end else mem_rdata <= mem[mem_addr[9:2]];
        end else wcnt <= wcnt + 1;
      end
    end
  end

  int total = 0, fails = 0, done_cnt = 0, nreads = 0, hold_err = 0, cyc = 0;
  logic [AW-1:0] rd_log [0:15];
  logic          prev_pend = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [31:0]   prev_wdata = '0;

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (mem_req && mem_ack && !mem_we && nreads < 16) begin
      rd_log[nreads] = mem_addr;
      nreads++;
    end
    if (prev_pend && (mem_req !== 1'b1 || mem_addr !== prev_addr || mem_wdata !== prev_wdata))
      hold_err++;
    prev_pend  = mem_req && !mem_ack;
    prev_addr  = mem_addr;
    prev_wdata = mem_wdata;
    cyc++;
    if (cyc == 150000) begin
      total++; fails++;
      $display("FAIL R8 watchdog: actual done_cnt %0d expected run to finish", done_cnt);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_list(input logic [AW-1:0] a);
    @(negedge clk); lp_we = 1'b1; lp_val = a;
    @(negedge clk); lp_we = 1'b0;
  endtask

  task automatic wr_poll(input logic [7:0] p);
    @(negedge clk); pp_we = 1'b1; pp_val = p;
    @(negedge clk); pp_we = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic last, input logic [4:0] e);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_last = last; rx_err = last ? e : 5'd0;
    while (!rx_ready) @(negedge clk);
    @(posedge clk);
    #1 rx_valid = 1'b0; rx_last = 1'b0; rx_err = '0;
  endtask

  task automatic wait_done(input int n);
    while (done_cnt < n) @(negedge clk);
  endtask

  task automatic quiet_window(input string req, input int n);
    int reqs = 0, rdys = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mem_req) reqs++;
      if (rx_ready) rdys++;
    end
    chk(req, reqs, 0);
    chk(req, rdys, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 req", mem_req, 0);
    chk("R1 done", done, 0);
    chk("R1 ready", rx_ready, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req after release", mem_req, 0);
    quiet_window("R2 null pointer", 20);
  endtask

  // descriptor A 0x100 -> B 0x140 -> A; buffers 0x200 / 0x280
  task automatic t_basic;
    mem[8'h40] = 32'h0000_0140; mem[8'h41] = 0;
    mem[8'h42] = 32'h0000_0200; mem[8'h43] = 32'h8000_0040;
    mem[8'h50] = 32'h0000_0100; mem[8'h51] = 0;
    mem[8'h52] = 32'h0000_0280; mem[8'h53] = 32'h8000_0005;
    for (int i = 0; i < 4; i++) begin
      mem[8'h80 + i] = 32'hAAAA_AAAA;
      mem[8'hA0 + i] = 32'hAAAA_AAAA;
    end
    wr_poll(8'd3);
    wr_list(16'h0100);
    for (int i = 0; i < 6; i++) send_byte(8'h11 * (i + 1), i == 5, 5'd0);
    wait_done(1);
    chk("R3 fetch word0", rd_log[0], 16'h0100);
    chk("R3 fetch word1", rd_log[1], 16'h0104);
    chk("R3 fetch word2", rd_log[2], 16'h0108);
    chk("R3 fetch word3", rd_log[3], 16'h010C);
    chk("R5 full word", mem[8'h80], 32'h4433_2211);
    chk("R5 partial word", mem[8'h81], 32'hAAAA_6655);
    chk("R7 status A", mem[8'h41], 32'h0000_8006);
    chk("R8 done count", done_cnt, 1);
  endtask

  task automatic t_overflow;
    lat = 2;
    for (int i = 0; i < 8; i++) send_byte(8'(i + 1), i == 7, 5'h05);
    wait_done(2);
    lat = 0;
    chk("R10 follows link", rd_log[4], 16'h0140);
    chk("R6 stored word", mem[8'hA0], 32'h0403_0201);
    chk("R6 cut word", mem[8'hA1], 32'hAAAA_AA05);
    chk("R6 untouched", mem[8'hA2], 32'hAAAA_AAAA);
    chk("R7 R6 status B", mem[8'hA0 - 8'h4F], 32'h0005_C005);
    chk("R9 hold", hold_err, 0);
  endtask

  task automatic t_poll;
    int low = 0, rdy = 0;
    while (mem_req) @(negedge clk);
    while (!mem_req) begin
      low++;
      if (rx_ready) rdy++;
      @(negedge clk);
    end
    chk("R4 poll idle cycles", low, 3 * UNIT + 1);
    chk("R4 refetch same descriptor", mem_addr, 16'h0100);
    chk("R4 no bytes taken", rdy, 0);
    chk("R4 done unchanged", done_cnt, 2);
  endtask

  task automatic t_refill;
    mem[8'h80] = 32'hAAAA_AAAA;
    mem[8'h41] = 0;
    wr_poll(8'd50);
    send_byte(8'h77, 1'b1, 5'd0);
    wait_done(3);
    chk("R5 single byte", mem[8'h80], 32'hAAAA_AA77);
    chk("R4 R7 status after release", mem[8'h41], 32'h0000_8001);
  endtask

  task automatic t_stop;
    while (mem_req) @(negedge clk);
    @(negedge clk);
    wr_list('0);
    quiet_window("R2 zero written while waiting", 60);
    chk("R4 filled status kept", mem[8'h51], 32'h0005_C005);
  endtask

  task automatic t_exact;
    mem[8'h60] = 0; mem[8'h61] = 0;
    mem[8'h62] = 32'h0000_0300; mem[8'h63] = 32'h8000_0008;
    for (int i = 0; i < 3; i++) mem[8'hC0 + i] = 32'hAAAA_AAAA;
    wr_list(16'h0180);
    for (int i = 0; i < 8; i++) send_byte(8'hA0 + 8'(i), i == 7, 5'd0);
    wait_done(4);
    chk("R6 exact word0", mem[8'hC0], 32'hA3A2_A1A0);
    chk("R6 exact word1", mem[8'hC1], 32'hA7A6_A5A4);
    chk("R6 beyond buffer", mem[8'hC2], 32'hAAAA_AAAA);
    chk("R6 exact fill no overflow", mem[8'h61], 32'h0000_8008);
    quiet_window("R10 zero link idles", 40);
    chk("R8 total done", done_cnt, 4);
    chk("R9 hold final", hold_err, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    t_reset();
    t_basic();
    t_overflow();
    t_poll();
    t_refill();
    t_stop();
    t_exact();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule